// File: doc/BRIEF.md
# Prescaled Up-Counting Timer

This block is a free-running up counter whose rate is divided down from the peripheral clock by a programmable prescaler. Software sets a prescale limit. A prescale counter steps once per clock while counting is enabled. Each time the prescale counter equals the limit, the main timer counter advances by one and the prescale counter restarts from zero. The timer therefore ticks once every limit+1 clocks.

Software uses a small synchronous register port with an address, a write strobe, write data and combinational read data. The port exposes a control word, the timer value, the prescale limit and the prescale count. The control word has two bits. One enables counting. The other holds both counters cleared for as long as it is set. Software can load either counter directly. The timer wraps silently at its full-scale value and raises no flag or interrupt.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control word, timer value, prescale limit and prescale count all read as zero.
- R2: While counting is enabled, clear is off, no load targets it and the prescale count differs from the limit, the prescale count rises by one on each clock and the timer value holds.
- R3: While counting is enabled and clear is off, a clock on which the prescale count equals the limit advances the timer value by one and returns the prescale count to zero. The timer thus steps every limit+1 clocks: every clock for limit 0, every 2 for limit 1, every 4 for limit 3.
- R4: The timer value counts from 0xFFFFFFFF to 0x00000000 and carries on with no other effect.
- R5: With control bit 0 (enable) at 0, both counters keep their values.
- R6: With control bit 1 (clear) at 1, both counters are zero from the next clock edge onward and stay zero while the bit remains set. Clear overrides both counting and software loads.
- R7: Control bits 31:2 ignore writes and read as zero.
- R8: Byte offsets are 0x04 for control, 0x08 for the timer value, 0x0C for the prescale limit and 0x10 for the prescale count. Every other offset reads as zero, and writes to it change no register.
- R9: A write to offset 0x08 or 0x10 loads that counter on the same edge. The load wins over counting in that cycle.
- R10: If the prescale count is above the limit, it keeps rising, wraps through 0xFFFFFFFF to 0, and matches the limit only when it next reaches it.
- R11: The read data reflects the register at the presented address in the same cycle, with no clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all registers |
| addr | input | ADDR_W (5) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for addr |

## Verification
The bench steps the limit through 0, 1 and 3 and counts timer advances over fixed windows. An off-by-one prescaler, one that divides by the limit rather than limit+1, shows up as a wrong increment count. It preloads the timer just below full scale and the prescale count above the limit. A design that saturates, or that compares with greater-or-equal, would freeze the timer or fire the match early. It also sets clear while enabled and writes to the counters during clear. A clear that acts only once, or that lets a load through, leaves non-zero counts. Loads during active counting catch a design that adds the increment to the loaded value.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   localparam int unsigned OFF_CTRL = 32'h04;
   localparam int unsigned OFF_TC   = 32'h08;
   localparam int unsigned OFF_PR   = 32'h0C;
   localparam int unsigned OFF_PC   = 32'h10;

   typedef struct packed {
      logic clr;
      logic en;
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_TC,
      SEL_PR,
      SEL_PC
   } sel_e;

endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode
   import ptmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_TC   = ADDR_W'(OFF_TC);
   localparam logic [ADDR_W-1:0] A_PR   = ADDR_W'(OFF_PR);
   localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(OFF_PC);

   always_comb begin
      unique case (addr)
         A_CTRL:  sel = SEL_CTRL;
         A_TC:    sel = SEL_TC;
         A_PR:    sel = SEL_PR;
         A_PC:    sel = SEL_PC;
         default: sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/ptmr_cfg_regs.sv
module ptmr_cfg_regs
   import ptmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  sel_e              sel,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  limit,
   output logic              ld_tc,
   output logic              ld_pc
);

   logic unused_hi;
   assign unused_hi = ^wdata[DATA_W-1:2];

   assign ld_tc = wr_en && (sel == SEL_TC);
   assign ld_pc = wr_en && (sel == SEL_PC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         limit <= '0;
      end else if (wr_en) begin
         if (sel == SEL_CTRL) begin
            ctrl.en  <= wdata[0];
            ctrl.clr <= wdata[1];
         end
         if (sel == SEL_PR) begin
            limit <= wdata[CNT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
   import ptmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctrl_t            ctrl,
   input  logic [CNT_W-1:0] limit,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] count,
   output logic             tick
);

   logic at_limit;

   assign at_limit = (count == limit);
   assign tick     = ctrl.en && !ctrl.clr && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (ctrl.clr) begin
         count <= '0;
      end else if (ld) begin
         count <= ld_val;
      end else if (ctrl.en) begin
         count <= at_limit ? '0 : count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             step,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (ld) begin
         count <= ld_val;
      end else if (step) begin
         count <= count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   initial begin : p_param_chk
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $fatal(1, "CNT_W out of range");
      assert (ADDR_W >= 5 && ADDR_W <= 32) else $fatal(1, "ADDR_W out of range");
   end

   sel_e              sel;
   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  pr_q;
   logic [CNT_W-1:0]  pc_q;
   logic [CNT_W-1:0]  tc_q;
   logic              ld_tc;
   logic              ld_pc;
   logic              tick;
   logic [DATA_W-1:0] tc_rd;
   logic [DATA_W-1:0] pc_rd;
   logic [DATA_W-1:0] pr_rd;
   logic [DATA_W-1:0] ctrl_rd;

   ptmr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   ptmr_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .sel   (sel),
      .wdata (wdata),
      .ctrl  (ctrl_q),
      .limit (pr_q),
      .ld_tc (ld_tc),
      .ld_pc (ld_pc)
   );

   ptmr_prescaler #(.CNT_W(CNT_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ctrl_q),
      .limit  (pr_q),
      .ld     (ld_pc),
      .ld_val (wdata[CNT_W-1:0]),
      .count  (pc_q),
      .tick   (tick)
   );

   ptmr_counter #(.CNT_W(CNT_W)) u_tc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctrl_q.clr),
      .ld     (ld_tc),
      .ld_val (wdata[CNT_W-1:0]),
      .step   (tick),
      .count  (tc_q)
   );

   // Counters narrower than the bus are zero-extended on read.
   if (CNT_W == DATA_W) begin : g_full
      assign tc_rd = tc_q;
      assign pc_rd = pc_q;
      assign pr_rd = pr_q;
   end else begin : g_ext
      assign tc_rd = {{(DATA_W-CNT_W){1'b0}}, tc_q};
      assign pc_rd = {{(DATA_W-CNT_W){1'b0}}, pc_q};
      assign pr_rd = {{(DATA_W-CNT_W){1'b0}}, pr_q};
   end

   assign ctrl_rd = {{(DATA_W-2){1'b0}}, ctrl_q.clr, ctrl_q.en};

   always_comb begin
      unique case (sel)
         SEL_CTRL: rdata = ctrl_rd;
         SEL_TC:   rdata = tc_rd;
         SEL_PR:   rdata = pr_rd;
         SEL_PC:   rdata = pc_rd;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
   import ptmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              en,
   input logic              clr,
   input logic [CNT_W-1:0]  tc,
   input logic [CNT_W-1:0]  pc,
   input logic [CNT_W-1:0]  pr
);

   logic wr_tc, wr_pc, mapped;
   assign wr_tc  = wr_en && (addr == ADDR_W'(OFF_TC));
   assign wr_pc  = wr_en && (addr == ADDR_W'(OFF_PC));
   assign mapped = (addr == ADDR_W'(OFF_CTRL)) || (addr == ADDR_W'(OFF_TC)) ||
                   (addr == ADDR_W'(OFF_PR))   || (addr == ADDR_W'(OFF_PC));

   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !wr_pc && pc != pr) |=> pc == CNT_W'($past(pc) + CNT_W'(1)));

   a_r3_pc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !wr_pc && pc == pr) |=> pc == '0);

   a_r3_tc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !wr_tc && pc == pr) |=> tc == CNT_W'($past(tc) + CNT_W'(1)));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !wr_tc && !wr_pc) |=> ($stable(tc) && $stable(pc)));

   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tc == '0 && pc == '0));

   a_r7_ctrl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFF_CTRL)) |-> rdata[DATA_W-1:2] == '0);

   a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> rdata == '0);

   a_r9_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pc && !clr) |=> pc == $past(wdata[CNT_W-1:0]));

   a_r9_tc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tc && !clr) |=> tc == $past(wdata[CNT_W-1:0]));

endmodule

bind ptmr_top ptmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (addr),
   .wr_en (wr_en),
   .wdata (wdata),
   .rdata (rdata),
   .en    (ctrl_q.en),
   .clr   (ctrl_q.clr),
   .tc    (tc_q),
   .pc    (pc_q),
   .pr    (pr_q)
);

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_CTRL = 5'h04;
   localparam logic [4:0] A_TC   = 5'h08;
   localparam logic [4:0] A_PR   = 5'h0C;
   localparam logic [4:0] A_PC   = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int total = 0;
   int bad = 0;
   logic [31:0] last;
   logic [31:0] m_ctrl, m_tc, m_pr, m_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptmr_top u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr_en (wr_en),
      .wdata (wdata),
      .rdata (rdata)
   );

   function automatic logic [31:0] mread(input logic [4:0] a);
      case (a)
         A_CTRL:  return m_ctrl;
         A_TC:    return m_tc;
         A_PR:    return m_pr;
         A_PC:    return m_pc;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: drive, compare read against the model, then advance the model.
   task automatic step(input logic [4:0] a, input logic we, input logic [31:0] d, input string tag);
      logic hit;
      logic [31:0] ntc, npc;
      @(negedge clk);
      addr = a; wr_en = we; wdata = d;
      #1;
      last = rdata;
      chk(tag, rdata, mread(a));
      @(posedge clk);
      hit = (m_pc == m_pr);
      if (m_ctrl[1]) ntc = 0;
      else if (we && a == A_TC) ntc = d;
      else if (m_ctrl[0] && hit) ntc = m_tc + 1;
      else ntc = m_tc;
      if (m_ctrl[1]) npc = 0;
      else if (we && a == A_PC) npc = d;
      else if (m_ctrl[0]) npc = hit ? 32'h0 : m_pc + 1;
      else npc = m_pc;
      if (we && a == A_CTRL) m_ctrl = d & 32'h3;
      if (we && a == A_PR) m_pr = d;
      m_tc = ntc; m_pc = npc;
      #1 wr_en = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      step(a, 1'b1, d, tag);
   endtask

   task automatic rd(input logic [4:0] a, input string tag);
      step(a, 1'b0, 32'h0, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] a0, p0;
      m_ctrl = 0; m_tc = 0; m_pr = 0; m_pc = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      rd(A_CTRL, "R1 ctrl"); chk("R1 ctrl", last, 0);
      rd(A_TC,   "R1 tc");   chk("R1 tc", last, 0);
      rd(A_PR,   "R1 pr");   chk("R1 pr", last, 0);
      rd(A_PC,   "R1 pc");   chk("R1 pc", last, 0);

      // R8 unmapped offsets
      rd(5'h00, "R8 off00"); chk("R8 off00", last, 0);
      rd(5'h14, "R8 off14"); chk("R8 off14", last, 0);
      wr(5'h14, 32'hFFFF_FFFF, "R8 wr14");
      wr(5'h00, 32'hFFFF_FFFF, "R8 wr00");
      rd(A_CTRL, "R8 ctrl"); chk("R8 ctrl untouched", last, 0);
      rd(A_PR,   "R8 pr");   chk("R8 pr untouched", last, 0);

      // R7 reserved control bits
      wr(A_CTRL, 32'hFFFF_FFFC, "R7 wr");
      rd(A_CTRL, "R7 rd"); chk("R7 reserved read zero", last, 0);
      rd(A_TC, "R7 tc"); rd(A_TC, "R7 tc"); chk("R7 no counting", last, 0);

      // R3 limit 0: one advance per clock
      wr(A_CTRL, 32'h1, "R3 en");
      rd(A_TC, "R3 pr0"); a0 = last;
      for (int i = 0; i < 6; i++) rd(A_TC, "R3 pr0");
      chk("R3 limit0 advances", last - a0, 6);

      // R3 limit 1: one advance per two clocks
      wr(A_PR, 32'h1, "R3 pr1 wr");
      rd(A_TC, "R3 pr1"); a0 = last;
      for (int i = 0; i < 10; i++) rd(A_TC, "R3 pr1");
      chk("R3 limit1 advances", last - a0, 5);

      // R3 limit 3: one advance per four clocks
      wr(A_PR, 32'h3, "R3 pr3 wr");
      rd(A_TC, "R3 pr3"); a0 = last;
      for (int i = 0; i < 12; i++) rd(A_TC, "R3 pr3");
      chk("R3 limit3 advances", last - a0, 3);

      // R2 prescale count steps by one
      wr(A_PR, 32'd9, "R2 pr");
      wr(A_PC, 32'd0, "R2 load");
      for (int i = 0; i < 3; i++) begin
         rd(A_PC, "R2 pc"); chk("R2 pc step", last, i);
      end

      // R5 disabled counters hold
      wr(A_CTRL, 32'h0, "R5 dis");
      rd(A_TC, "R5"); a0 = last;
      rd(A_PC, "R5"); p0 = last;
      for (int i = 0; i < 5; i++) rd(A_TC, "R5");
      chk("R5 tc holds", last, a0);
      rd(A_PC, "R5"); chk("R5 pc holds", last, p0);

      // R9 loads, idle and while counting
      wr(A_TC, 32'h1234, "R9 tc"); rd(A_TC, "R9"); chk("R9 tc load", last, 32'h1234);
      wr(A_PC, 32'd7, "R9 pc");    rd(A_PC, "R9"); chk("R9 pc load", last, 7);
      wr(A_CTRL, 32'h1, "R9 en");
      wr(A_TC, 32'hABCD, "R9 tc cnt"); rd(A_TC, "R9"); chk("R9 load beats count", last, 32'hABCD);

      // R4 timer wrap
      wr(A_CTRL, 32'h0, "R4");
      wr(A_PR, 32'h0, "R4");
      wr(A_TC, 32'hFFFF_FFFE, "R4");
      wr(A_CTRL, 32'h1, "R4");
      rd(A_TC, "R4"); chk("R4 wrap a", last, 32'hFFFF_FFFE);
      rd(A_TC, "R4"); chk("R4 wrap b", last, 32'hFFFF_FFFF);
      rd(A_TC, "R4"); chk("R4 wrap c", last, 32'h0);
      rd(A_TC, "R4"); chk("R4 wrap d", last, 32'h1);

      // R10 prescale count above the limit wraps before matching
      wr(A_CTRL, 32'h0, "R10");
      wr(A_PR, 32'd5, "R10");
      wr(A_PC, 32'hFFFF_FFFE, "R10");
      wr(A_TC, 32'h0, "R10");
      wr(A_CTRL, 32'h1, "R10");
      for (int i = 0; i < 8; i++) begin
         rd(A_PC, "R10 pc"); chk("R10 pc sequence", last, 32'hFFFF_FFFE + 32'(i));
      end
      rd(A_PC, "R10 pc"); chk("R10 pc restart", last, 0);
      rd(A_TC, "R10 tc"); chk("R10 single advance", last, 1);

      // R6 clear holds counters at zero
      wr(A_CTRL, 32'h3, "R6 set");
      rd(A_TC, "R6");
      rd(A_TC, "R6"); chk("R6 tc cleared", last, 0);
      rd(A_PC, "R6"); chk("R6 pc cleared", last, 0);
      wr(A_TC, 32'h55, "R6 wr tc");
      rd(A_TC, "R6"); chk("R6 load blocked", last, 0);
      wr(A_PC, 32'd9, "R6 wr pc");
      rd(A_PC, "R6"); chk("R6 pc load blocked", last, 0);
      wr(A_CTRL, 32'h1, "R6 release");
      rd(A_TC, "R6"); chk("R6 restart from zero", last, 0);
      for (int i = 0; i < 8; i++) rd(A_TC, "R6 run");

      // R11 read is combinational on address change
      @(negedge clk);
      addr = A_PR; #1; chk("R11 same-cycle pr", rdata, m_pr);
      addr = A_CTRL; #1; chk("R11 same-cycle ctrl", rdata, m_ctrl);
      addr = 5'h1C; #1; chk("R11 same-cycle unmapped", rdata, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule